// File: doc/BRIEF.md
# Transmit Serial Port Sequencer

This block sits between an external MAC and the transmit chain of a spread-spectrum baseband. While the MAC holds the packet-enable input high, the block drives a bit clock toward the MAC, takes one serial transmit bit per bit period, and packs the payload bits into bytes for the modulator. The bit clock comes from the system clock through a divider whose ratio comes from a rate code. The code is captured when a packet starts, so the bit rate follows the rate that the header signalling field carries.

When internal preamble generation is selected, the block first produces a run of sync ones, a 16-bit start-frame delimiter and a 48-bit header, one bit per period, on a serial framing output. Only after the last header bit does it raise a ready flag, and the MAC then starts shifting payload. In external mode the payload phase starts at once and the ready flag never rises. Dropping the enable ends the packet at once from any phase. Any byte left incomplete at that point is lost.

Top module: `tx_serial_seq`

## Requirements
- R1: After reset, and while packet-enable has never been high, `bclk`, `tx_rdy`, `hdr_bit_vld` and `byte_vld` are all low.
- R2: The bit clock is held low in idle. A rising edge of `tx_en` starts it. Each bit period lasts 2^(rate_sel+1) system clocks, with `rate_sel` captured at the start edge. `bclk` is high for the first half of each period and low for the second half.
- R3: In internal mode (`pre_mode`=1) the framing output gives SYNC_BITS ones, then SFD_WORD from bit 0 upward, then `hdr_fields` from bit 0 upward. `hdr_bit_vld` pulses for one cycle at the end of each bit period, together with that period's bit on `hdr_bit`.
- R4: In internal mode `tx_rdy` rises at the end of the last header bit period and stays high until `tx_en` falls. In external mode it stays low.
- R5: With `edge_sel`=0, payload is sampled from `txd` at the falling edge of `bclk`, least significant bit first. Every eighth bit gives a one-cycle `byte_vld` with the byte, starting in the cycle that follows the sampling edge of bit 7.
- R6: With `edge_sel`=1, payload is sampled at the end of each bit period, where `bclk` rises again. Byte assembly and pulse timing are otherwise as in R5.
- R7: A falling edge of `tx_en` returns the block to idle in one cycle from any phase. In the next cycle `bclk` and `tx_rdy` are low, and no further framing or byte pulses appear.
- R8: A partial byte at the end of a packet is discarded. The next packet's first byte holds only that packet's first eight payload bits.
- R9: In external mode (`pre_mode`=0) payload sampling begins in the first bit period after the start edge, and `hdr_bit_vld` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Packet-enable envelope from the MAC |
| txd | input | 1 | Serial transmit data from the MAC |
| rate_sel | input | 2 | Divide code: bit period = 2^(code+1) clocks |
| pre_mode | input | 1 | 1 = block generates preamble and header |
| edge_sel | input | 1 | 0 = sample at bclk fall, 1 = at bclk rise |
| hdr_fields | input | 48 | Header contents (signal, service, length, CRC) |
| bclk | output | 1 | Bit clock toward the MAC |
| tx_rdy | output | 1 | Preamble and header done, payload accepted |
| hdr_bit | output | 1 | Framing bit toward the modulator |
| hdr_bit_vld | output | 1 | One-cycle strobe for hdr_bit |
| byte_out | output | 8 | Assembled payload byte |
| byte_vld | output | 1 | One-cycle strobe for byte_out |

## Verification
The bench counts cycles c from the system edge that takes the start edge, and knows the period d and the preamble length P. `bclk` must equal (c mod d) < d/2. Framing bit b must appear in the cycle after edge (b+1)·d, and `tx_rdy` from the cycle after edge P·d. Payload bit j is taken at edge (P+j)·d + d/2, or at (P+j+1)·d for the rising-edge option, and its byte strobe follows one cycle later. The bench drives `txd` on falling system edges, holds each payload bit for its whole period, and samples every output on falling system edges. Each check therefore lands one register stage after the edge that produced it. After the enable falls, the outputs are checked in the very next cycle.

// File: rtl/txs_pkg.sv
// Shared types and fixed framing lengths for the transmit serial sequencer.
package txs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } txs_state_e;

    localparam int SFD_LEN = 16;
    localparam int HDR_LEN = 48;
endpackage

// File: rtl/txs_bitclk.sv
// Bit-clock divider.
// Makes the MAC-facing bit clock and two strobes: mid_stb one cycle before the
// high-to-low change, end_stb on the last cycle of each bit period.
// Assumes run is a registered level; the divide code is captured while idle.
module txs_bitclk #(
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              bclk,
    output logic              mid_stb,
    output logic              end_stb
);
    localparam int CNT_W = 1 << RATE_W;

    logic [RATE_W-1:0] rate_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W:0]    div_v;
    logic [CNT_W:0]    half_v;
    logic [CNT_W:0]    cnt_x;

    // Period length and half-period from the captured code.
    always_comb begin
        div_v  = {{CNT_W{1'b0}}, 1'b1} << ({1'b0, rate_q} + 1'b1);
        half_v = div_v >> 1;
        cnt_x  = {1'b0, cnt};
    end

    // Capture the divide code only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)   rate_q <= '0;
        else if (!run) rate_q <= rate_sel;
    end

    // Count the position inside the bit period, parked at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)          cnt <= '0;
        else if (cnt_x == div_v - 1'b1) cnt <= '0;
        else                         cnt <= cnt + 1'b1;
    end

    // Bit clock and strobes from the period position.
    always_comb begin
        bclk    = run && (cnt_x < half_v);
        mid_stb = run && (cnt_x == half_v - 1'b1);
        end_stb = run && (cnt_x == div_v - 1'b1);
    end

    assert_rate_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(rate_q));
    assert_period_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        end_stb |=> (bclk || !run));
    assert_mid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mid_stb |=> !bclk);
endmodule

// File: rtl/txs_hdr_gen.sv
// Preamble and header generator.
// On load it captures the header fields. Each adv emits one framing bit:
// SYNC_BITS ones, then SFD_WORD and the header shifted out LSB first.
// done marks the adv that emits the final header bit.
module txs_hdr_gen
    import txs_pkg::*;
#(
    parameter int              SYNC_BITS = 128,
    parameter logic [SFD_LEN-1:0] SFD_WORD = 16'hF3A0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               abort,
    input  logic               adv,
    input  logic [HDR_LEN-1:0] fields,
    output logic               hdr_bit,
    output logic               hdr_vld,
    output logic               done
);
    localparam int TAIL_LEN = SFD_LEN + HDR_LEN;
    localparam int SYNC_W   = $clog2(SYNC_BITS + 1);
    localparam int TAIL_W   = $clog2(TAIL_LEN + 1);

    logic [TAIL_LEN-1:0] tail_sr;
    logic [SYNC_W-1:0]   sync_cnt;
    logic [TAIL_W-1:0]   tail_cnt;
    logic                in_sync;
    logic                cur_bit;

    // Select the sync phase or the delimiter/header tail.
    always_comb begin
        in_sync = (sync_cnt != SYNC_W'(SYNC_BITS));
        cur_bit = in_sync ? 1'b1 : tail_sr[0];
        done    = adv && !in_sync && (tail_cnt == TAIL_W'(TAIL_LEN - 1));
    end

    // Step through the framing sequence one bit per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_sr  <= '0;
            sync_cnt <= '0;
            tail_cnt <= '0;
        end else if (load) begin
            tail_sr  <= {fields, SFD_WORD};
            sync_cnt <= '0;
            tail_cnt <= '0;
        end else if (adv && !abort) begin
            if (in_sync) begin
                sync_cnt <= sync_cnt + 1'b1;
            end else begin
                tail_sr  <= tail_sr >> 1;
                tail_cnt <= tail_cnt + 1'b1;
            end
        end
    end

    // Register the emitted bit with its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_bit <= 1'b0;
            hdr_vld <= 1'b0;
        end else begin
            hdr_vld <= adv && !abort;
            if (adv && !abort) hdr_bit <= cur_bit;
        end
    end

    assert_hdr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |=> !hdr_vld);
    assert_sync_bits_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !abort && !load && in_sync) |=> (hdr_vld && hdr_bit));
    assert_tail_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tail_cnt <= TAIL_W'(TAIL_LEN));
endmodule

// File: rtl/txs_ctrl.sv
// Packet control state machine.
// Detects enable edges, picks the preamble or payload phase, and keeps the
// ready flag. A falling enable wins over every other event.
// Assumes tx_en is already synchronous to clk.
module txs_ctrl
    import txs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic pre_mode,
    input  logic hdr_done,
    output logic run,
    output logic in_pre,
    output logic in_data,
    output logic start,
    output logic abort,
    output logic rdy
);
    txs_state_e state;
    logic       en_q;
    logic       mode_q;
    logic       rise;

    // Edge detection on the enable envelope.
    always_comb begin
        rise    = tx_en && !en_q;
        abort   = !tx_en && en_q;
        start   = rise && (state == ST_IDLE);
        run     = (state != ST_IDLE);
        in_pre  = (state == ST_PRE);
        in_data = (state == ST_DATA);
    end

    // Delay the enable by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= tx_en;
    end

    // Phase sequencing and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            rdy    <= 1'b0;
            mode_q <= 1'b0;
        end else if (abort) begin
            state <= ST_IDLE;
            rdy   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= pre_mode ? ST_PRE : ST_DATA;
                    mode_q <= pre_mode;
                end
                ST_PRE: if (hdr_done) begin
                    state <= ST_DATA;
                    rdy   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assert_fall_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state == ST_IDLE && !rdy));
    assert_rdy_only_internal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> mode_q);
    assert_idle_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !rise) |=> (state == ST_IDLE));
endmodule

// File: rtl/txs_byte_pack.sv
// Payload byte packer.
// Shifts serial bits in LSB first and gives a one-cycle strobe with each
// complete byte. clear drops a partial byte and outranks shift_en.
module txs_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              din,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    localparam int CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr;
    logic [CW-1:0]     cnt;
    logic [BYTE_W-1:0] nxt;

    // Shift-register value after taking the new bit.
    always_comb nxt = {din, sr[BYTE_W-1:1]};

    // Collect bits and release full bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            cnt      <= '0;
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (clear) begin
                cnt <= '0;
            end else if (shift_en) begin
                sr <= nxt;
                if (cnt == CW'(BYTE_W - 1)) begin
                    byte_out <= nxt;
                    byte_vld <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_byte_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
    assert_clear_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !byte_vld);
endmodule

// File: rtl/tx_serial_seq.sv
// Transmit serial port sequencer, top level.
// Joins the control FSM, bit-clock divider, framing generator and byte packer.
// Assumes every input is synchronous to clk; edge_sel is held for a whole packet.
module tx_serial_seq
    import txs_pkg::*;
#(
    parameter int                 RATE_W    = 2,
    parameter int                 SYNC_BITS = 128,
    parameter logic [SFD_LEN-1:0] SFD_WORD  = 16'hF3A0,
    parameter int                 BYTE_W    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               txd,
    input  logic [RATE_W-1:0]  rate_sel,
    input  logic               pre_mode,
    input  logic               edge_sel,
    input  logic [HDR_LEN-1:0] hdr_fields,
    output logic               bclk,
    output logic               tx_rdy,
    output logic               hdr_bit,
    output logic               hdr_bit_vld,
    output logic [BYTE_W-1:0]  byte_out,
    output logic               byte_vld
);
    logic run, in_pre, in_data, start, abort, hdr_done;
    logic mid_stb, end_stb, samp_stb, adv;

    // Pick the sampling edge and gate the framing advance.
    always_comb begin
        samp_stb = edge_sel ? end_stb : mid_stb;
        adv      = in_pre && end_stb && !abort;
    end

    txs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .pre_mode(pre_mode),
        .hdr_done(hdr_done), .run(run), .in_pre(in_pre), .in_data(in_data),
        .start(start), .abort(abort), .rdy(tx_rdy)
    );

    txs_bitclk #(.RATE_W(RATE_W)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .run(run), .rate_sel(rate_sel),
        .bclk(bclk), .mid_stb(mid_stb), .end_stb(end_stb)
    );

    txs_hdr_gen #(.SYNC_BITS(SYNC_BITS), .SFD_WORD(SFD_WORD)) u_hdr (
        .clk(clk), .rst_n(rst_n), .load(start), .abort(abort), .adv(adv),
        .fields(hdr_fields), .hdr_bit(hdr_bit), .hdr_vld(hdr_bit_vld),
        .done(hdr_done)
    );

    txs_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear(!in_data || abort),
        .shift_en(in_data && samp_stb), .din(txd),
        .byte_out(byte_out), .byte_vld(byte_vld)
    );
endmodule

// File: tb/test_tx_serial_seq.sv
module test_tx_serial_seq;
    localparam int          SYNC = 8;
    localparam int          NPRE = SYNC + 64;
    localparam logic [15:0] SFD  = 16'h9E2B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        txd = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic        pre_mode = 1'b0;
    logic        edge_sel = 1'b0;
    logic [47:0] hdr_fields = '0;
    logic        bclk, tx_rdy, hdr_bit, hdr_bit_vld, byte_vld;
    logic [7:0]  byte_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    tx_serial_seq #(.SYNC_BITS(SYNC), .SFD_WORD(SFD)) i_tx_serial_seq (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .txd(txd), .rate_sel(rate_sel),
        .pre_mode(pre_mode), .edge_sel(edge_sel), .hdr_fields(hdr_fields),
        .bclk(bclk), .tx_rdy(tx_rdy), .hdr_bit(hdr_bit), .hdr_bit_vld(hdr_bit_vld),
        .byte_out(byte_out), .byte_vld(byte_vld)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pay_byte(input int seed, input int k);
        return 8'((seed * 53 + k * 29 + 7) ^ (k << 3));
    endfunction

    function automatic logic pay_bit(input int seed, input int j);
        logic [7:0] b;
        b = pay_byte(seed, j / 8);
        return b[j % 8];
    endfunction

    function automatic logic [47:0] hdr_pat(input int seed);
        return {16'(seed * 97 + 3), 16'(seed * 13 + 5), 16'(~seed)};
    endfunction

    function automatic logic pre_bit(input int seed, input int b);
        logic [47:0] h;
        h = hdr_pat(seed);
        if (b < SYNC) return 1'b1;
        if (b < SYNC + 16) return SFD[b - SYNC];
        return h[b - SYNC - 16];
    endfunction

    function automatic logic drive_bit(input int seed, input int npre, input int nbits, input int b);
        if (b < npre) return 1'b0;
        if (b - npre < nbits) return pay_bit(seed, b - npre);
        return 1'b1;
    endfunction

    // One packet: c counts falling system edges after the edge taking tx_en's rise.
    task automatic run_pkt(input int rate, input bit edg, input bit mode, input int nbits, input int seed);
        int div, half, npre, tt, lim, off, j;
        string breq;
        div  = 1 << (rate + 1);
        half = div / 2;
        npre = mode ? NPRE : 0;
        tt   = npre + nbits;
        lim  = tt * div + 1;
        off  = edg ? div : half;
        @(negedge clk);
        rate_sel   = 2'(rate);
        edge_sel   = edg;
        pre_mode   = mode;
        hdr_fields = hdr_pat(seed);
        txd        = drive_bit(seed, npre, nbits, 0);
        tx_en      = 1'b1;
        for (int c = 0; c <= lim; c++) begin
            @(negedge clk);
            chk("R2", "bclk", bclk, ((c % div) < half) ? 1 : 0);
            if ((c % div == 0) && c > 0 && (c / div <= npre)) begin
                chk("R3", "hdr_bit_vld", hdr_bit_vld, 1);
                chk("R3", "hdr_bit", hdr_bit, pre_bit(seed, c / div - 1));
            end else begin
                chk(mode ? "R3" : "R9", "hdr_bit_vld idle", hdr_bit_vld, 0);
            end
            chk(mode ? "R4" : "R9", "tx_rdy", tx_rdy, (mode && c >= npre * div) ? 1 : 0);
            j = -1;
            if (c >= off && ((c - off) % div == 0)) j = (c - off) / div - npre;
            if (j >= 0 && j < nbits && (j % 8 == 7)) begin
                breq = (j == 7) ? "R8" : (!mode ? "R9" : (edg ? "R6" : "R5"));
                chk(breq, "byte_vld", byte_vld, 1);
                chk(breq, "byte_out", byte_out, pay_byte(seed, j / 8));
            end else begin
                chk(edg ? "R6" : "R5", "byte_vld quiet", byte_vld, 0);
            end
            txd = drive_bit(seed, npre, nbits, c / div);
            if (c == lim) tx_en = 1'b0;
        end
        @(negedge clk);
        chk("R7", "bclk after fall", bclk, 0);
        chk("R7", "tx_rdy after fall", tx_rdy, 0);
        chk("R7", "hdr_bit_vld after fall", hdr_bit_vld, 0);
        chk("R7", "byte_vld after fall", byte_vld, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            txd = ~txd;
            chk("R2", "bclk idle", bclk, 0);
        end
    endtask

    task automatic abort_pre(input int cut);
        @(negedge clk);
        rate_sel = 2'd0;
        pre_mode = 1'b1;
        edge_sel = 1'b0;
        tx_en    = 1'b1;
        for (int c = 0; c <= cut; c++) begin
            @(negedge clk);
            if (c == cut) tx_en = 1'b0;
        end
        @(negedge clk);
        chk("R7", "bclk after abort", bclk, 0);
        chk("R7", "tx_rdy after abort", tx_rdy, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R7", "hdr_bit_vld after abort", hdr_bit_vld, 0);
            chk("R7", "byte_vld after abort", byte_vld, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "bclk in reset", bclk, 0);
        chk("R1", "tx_rdy in reset", tx_rdy, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            txd = ~txd;
            chk("R1", "bclk", bclk, 0);
            chk("R1", "tx_rdy", tx_rdy, 0);
            chk("R1", "hdr_bit_vld", hdr_bit_vld, 0);
            chk("R1", "byte_vld", byte_vld, 0);
        end
        for (int m = 0; m < 2; m++)
            for (int e = 0; e < 2; e++)
                for (int r = 0; r < 4; r++)
                    run_pkt(r, e[0], m[0], 29, 1 + r + 4 * e + 8 * m);
        abort_pre(20);
        run_pkt(1, 1'b0, 1'b1, 16, 77);
        abort_pre(NPRE * 2 + 5);
        run_pkt(0, 1'b1, 1'b0, 24, 91);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule